// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a byte-wide parallel NOR flash bus. It turns bus write cycles into commands. A write cycle completes when the write-enable and chip-enable strobes are both low. The block recognises two unlock writes followed by an opcode. It can enter identifier mode, or arm a second unlock pair that leads to a chip-wide or sector-wide erase.

During an erase the block is self-timed. The ready/busy output stays low for a fixed number of clock cycles. Reads return a status byte instead of array data, and every write is dropped. When the count expires, the affected bytes become FFh and reads return array data again. An asynchronous active-low reset aborts an erase at once.

The storage behind the decoder is a small register stub with a fixed reset pattern. It exists so that the effect of an erase can be observed at the read port.

Top module: `flash_cmd_unit`

## Requirements
- R1: After reset, `rdyBusy` is 1 and `rdData` is 00h. Array byte i reads as (i XOR A0h), using the low IDX_W address bits.
- R2: A write cycle is taken in the clock cycle where (weN OR ceN) goes from 1 to 0. It uses `wrAddr` and `wrData` from that cycle, so the later of the two strobes to fall decides what is captured.
- R3: Writing AAh to 555h, then 55h to 2AAh, then 90h to 555h enters identifier mode.
- R4: An erase is the two unlock writes, then 80h to 555h, then the same two unlock writes, then a final write. The final write is 10h to 555h for chip erase, or 30h to any address for sector erase. For sector erase, the sector is selected by address bits [IDX_W-1:SECTOR_BITS] of that final write.
- R5: A write that does not match the next expected step returns the decoder to idle. A later write of a later step then has no effect.
- R6: `rdyBusy` goes low in the cycle after the final erase write. It stays low for exactly ERASE_CYCLES clock cycles.
- R7: A read while busy returns a status byte. Bit 7 is 0, bits 5..0 are 0, and bit 6 is the inverse of bit 6 from the previous busy read. The first busy read after reset has bit 6 = 1.
- R8: Every write cycle while busy is ignored. It neither changes the read mode nor starts a sequence.
- R9: On completion, a chip erase sets every byte to FFh, and a sector erase sets only the selected sector's bytes to FFh. Reads then return array data at the presented address, and two reads of the same address return the same value.
- R10: In identifier mode, a read at address 0 returns C2h, a read at address 1 returns 93h, and any other address returns 00h. A write of F0h while not busy returns the block to array reads.
- R11: Driving `rstN` low during an erase immediately sets `rdyBusy` to 1. After release the block reads array data, and no erase completes later.
- R12: `rdData` is loaded on a clock edge where `rdStb` is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| weN | input | 1 | Write enable, active low |
| ceN | input | 1 | Chip enable for write cycles, active low |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data |
| rdStb | input | 1 | Read request, one cycle |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Read result: array, identifier or status |
| rdyBusy | output | 1 | 1 = ready, 0 = erase in progress |

## Verification
The hardest situation to reach is a full, valid command sequence issued while an erase is still running. The decoder must ignore it, and its only trace would be a wrong read mode after completion. The bench starts a chip erase, takes two status reads, and then issues a complete identifier sequence before the busy count runs out. It waits for ready and expects FFh rather than C2h at address 0.

A second hard case is a final write whose address changes while write-enable is already low. The bench then drops chip-enable last, so only the later address may select the erased sector.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_UNL1, SEQ_UNL2, SEQ_SETUP, SEQ_UNL3, SEQ_UNL4
  } seqState_e;

  typedef enum logic [1:0] {
    MODE_ARRAY, MODE_IDENT, MODE_BUSY
  } readMode_e;

  // control -> datapath strobes
  typedef struct packed {
    readMode_e mode;
    logic      latchSect;
    logic      commitErase;
    logic      chipWide;
  } ctlStrobe_t;

  localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
  localparam logic [7:0] CODE_SETUP    = 8'h80;
  localparam logic [7:0] CODE_CHIP     = 8'h10;
  localparam logic [7:0] CODE_SECTOR   = 8'h30;
  localparam logic [7:0] CODE_IDENT    = 8'h90;
  localparam logic [7:0] CODE_EXIT     = 8'hF0;
  localparam logic [7:0] ID_MAKER      = 8'hC2;
  localparam logic [7:0] ID_DEVICE     = 8'h93;
  localparam logic [7:0] FILL_PATTERN  = 8'hA0;
endpackage

// File: rtl/flashcmd_ctrl.sv
module flashcmd_ctrl
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int ERASE_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              weN,
  input  logic              ceN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output ctlStrobe_t        ctl
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(12'h2AA);

  logic       strbHigh;
  logic       wrEvent;
  seqState_e  seqQ, seqNext;
  readMode_e  modeQ, modeNext;
  logic [CNT_W-1:0] cntQ;
  logic       chipQ;
  logic       startErase, chipSel, finishErase;
  logic       isUnlA, isUnlB, atA;

  // combined strobe: a cycle completes when the later strobe falls
  assign wrEvent = strbHigh & ~(weN | ceN);
  assign atA     = (wrAddr == ADDR_A);
  assign isUnlA  = atA && (wrData == CODE_UNLOCK_A);
  assign isUnlB  = (wrAddr == ADDR_B) && (wrData == CODE_UNLOCK_B);
  assign finishErase = (modeQ == MODE_BUSY) && (cntQ == '0);

  always_comb begin
    seqNext    = seqQ;
    modeNext   = modeQ;
    startErase = 1'b0;
    chipSel    = 1'b0;
    if (modeQ != MODE_BUSY && wrEvent) begin
      seqNext = SEQ_IDLE;
      if (wrData == CODE_EXIT) begin
        modeNext = MODE_ARRAY;
      end else begin
        unique case (seqQ)
          SEQ_IDLE:  if (isUnlA) seqNext = SEQ_UNL1;
          SEQ_UNL1:  if (isUnlB) seqNext = SEQ_UNL2;
          SEQ_UNL2: begin
            if (atA && wrData == CODE_IDENT)      modeNext = MODE_IDENT;
            else if (atA && wrData == CODE_SETUP) seqNext  = SEQ_SETUP;
          end
          SEQ_SETUP: if (isUnlA) seqNext = SEQ_UNL3;
          SEQ_UNL3:  if (isUnlB) seqNext = SEQ_UNL4;
          SEQ_UNL4: begin
            if (atA && wrData == CODE_CHIP) begin
              startErase = 1'b1;
              chipSel    = 1'b1;
            end else if (wrData == CODE_SECTOR) begin
              startErase = 1'b1;
            end
          end
          default: seqNext = SEQ_IDLE;
        endcase
      end
      if (startErase) modeNext = MODE_BUSY;
    end
    if (finishErase) modeNext = MODE_ARRAY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strbHigh <= 1'b1;
      seqQ     <= SEQ_IDLE;
      modeQ    <= MODE_ARRAY;
      cntQ     <= '0;
      chipQ    <= 1'b0;
    end else begin
      strbHigh <= weN | ceN;
      seqQ     <= seqNext;
      modeQ    <= modeNext;
      if (startErase) begin
        cntQ  <= CNT_W'(ERASE_CYCLES - 1);
        chipQ <= chipSel;
      end else if (modeQ == MODE_BUSY && cntQ != '0) begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end

  assign ctl.mode        = modeQ;
  assign ctl.latchSect   = startErase & ~chipSel;
  assign ctl.commitErase = finishErase;
  assign ctl.chipWide    = chipQ;
endmodule

// File: rtl/flashcmd_dpath.sv
module flashcmd_dpath
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int IDX_W       = 4,
  parameter int SECTOR_BITS = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobe_t              ctl,
  input  logic [IDX_W-1:SECTOR_BITS] wrSect,
  input  logic                    rdStb,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [7:0]              rdData
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int SNUM_W = IDX_W - SECTOR_BITS;

  logic [SNUM_W-1:0]        sectQ;
  logic                     toggleQ6;
  logic [DEPTH-1:0][7:0]    cellVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sectQ <= '0;
    else if (ctl.latchSect) sectQ <= wrSect;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gCell
    localparam logic [IDX_W-1:0]  IDX  = IDX_W'(i);
    localparam logic [SNUM_W-1:0] SECT = IDX[IDX_W-1:SECTOR_BITS];
    logic [7:0] cellQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cellQ <= 8'(i) ^ FILL_PATTERN;
      else if (ctl.commitErase && (ctl.chipWide || sectQ == SECT))
        cellQ <= 8'hFF;
    end
    assign cellVec[i] = cellQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= 8'h00;
      toggleQ6 <= 1'b0;
    end else if (rdStb) begin
      unique case (ctl.mode)
        MODE_BUSY: begin
          rdData   <= {1'b0, ~toggleQ6, 6'b0};
          toggleQ6 <= ~toggleQ6;
        end
        MODE_IDENT: begin
          if (rdAddr == ADDR_W'(0))      rdData <= ID_MAKER;
          else if (rdAddr == ADDR_W'(1)) rdData <= ID_DEVICE;
          else                           rdData <= 8'h00;
        end
        default: rdData <= cellVec[rdAddr[IDX_W-1:0]];
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_unit.sv
module flash_cmd_unit
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int IDX_W        = 4,
  parameter int SECTOR_BITS  = 2,
  parameter int ERASE_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              weN,
  input  logic              ceN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              rdyBusy
);
  ctlStrobe_t ctl;

  flashcmd_ctrl #(.ADDR_W(ADDR_W), .ERASE_CYCLES(ERASE_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .weN(weN), .ceN(ceN),
    .wrAddr(wrAddr), .wrData(wrData), .ctl(ctl)
  );

  flashcmd_dpath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SECTOR_BITS(SECTOR_BITS)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .wrSect(wrAddr[IDX_W-1:SECTOR_BITS]),
    .rdStb(rdStb), .rdAddr(rdAddr), .rdData(rdData)
  );

  assign rdyBusy = (ctl.mode != MODE_BUSY);
endmodule

// File: rtl/flash_cmd_unit_chk.sv
module flash_cmd_unit_chk #(
  parameter int ERASE_CYCLES = 24
) (
  input logic       clk,
  input logic       rstN,
  input logic       weN,
  input logic       ceN,
  input logic       rdStb,
  input logic [7:0] rdData,
  input logic       rdyBusy
);
  logic        prevHigh;
  logic        wrFall;
  int unsigned busyRun;
  logic        pendBusyRead;
  logic        lastQ6;
  logic        haveLast;

  assign wrFall = prevHigh & ~(weN | ceN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevHigh     <= 1'b1;
      busyRun      <= 0;
      pendBusyRead <= 1'b0;
      lastQ6       <= 1'b0;
      haveLast     <= 1'b0;
    end else begin
      prevHigh     <= weN | ceN;
      busyRun      <= rdyBusy ? 0 : busyRun + 1;
      pendBusyRead <= rdStb & ~rdyBusy;
      if (pendBusyRead) begin
        lastQ6   <= rdData[6];
        haveLast <= 1'b1;
      end
    end
  end

  // R6: busy never outlasts the configured count
  a_r6_busy_bound: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= ERASE_CYCLES);

  // R6: a busy phase that ends without reset lasted exactly the count
  a_r6_exact_length: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdyBusy) |-> busyRun == ERASE_CYCLES);

  // R4: busy only starts right after a completed write cycle
  a_r4_busy_after_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyBusy) |-> $past(wrFall));

  // R7: status byte has bit 7 and bits 5..0 clear
  a_r7_status_bits: assert property (@(posedge clk) disable iff (!rstN)
    rdStb && !rdyBusy |=> rdData[7] == 1'b0 && rdData[5:0] == 6'b0);

  // R7: bit 6 alternates between successive busy reads
  a_r7_toggle: assert property (@(posedge clk) disable iff (!rstN)
    pendBusyRead && haveLast |-> rdData[6] != lastQ6);

  // R11: reset forces ready
  always @(posedge clk) begin
    if (rstN === 1'b0) begin
      a_r11_reset_ready: assert (rdyBusy === 1'b1);
    end
  end
endmodule

bind flash_cmd_unit flash_cmd_unit_chk #(.ERASE_CYCLES(ERASE_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .weN(weN), .ceN(ceN),
  .rdStb(rdStb), .rdData(rdData), .rdyBusy(rdyBusy)
);

// File: tb/flash_cmd_unit_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_unit_tb_top;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 4;
  localparam int SBITS  = 2;
  localparam int NCYC   = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic weN = 1'b1;
  logic ceN = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic rdStb = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic rdyBusy;

  int total = 0;
  int fails = 0;
  logic q6Model;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SECTOR_BITS(SBITS),
                   .ERASE_CYCLES(NCYC)) dut_i (
    .clk(clk), .rstN(rstN), .weN(weN), .ceN(ceN), .wrAddr(wrAddr),
    .wrData(wrData), .rdStb(rdStb), .rdAddr(rdAddr), .rdData(rdData),
    .rdyBusy(rdyBusy)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i) ^ 8'hA0;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; weN = 1'b1; ceN = 1'b0; rdStb = 1'b0;
    q6Model = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    wrAddr = a; wrData = d; weN = 1'b0;
    @(negedge clk);
    weN = 1'b1;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    rdStb = 1'b1; rdAddr = a;
    @(negedge clk);
    rdStb = 1'b0;
    d = rdData;
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h55);
  endtask

  task automatic eraseHead();
    unlock();
    wr(12'h555, 8'h80);
    unlock();
  endtask

  task automatic waitReady();
    for (int k = 0; k < 4 * NCYC && !rdyBusy; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    doReset();
    check("R1 ready", {7'b0, rdyBusy}, 8'h01);
    check("R1 rdData", rdData, 8'h00);
    for (int i = 0; i < 16; i += 5) begin
      rd(ADDR_W'(i), d);
      check("R1 pattern", d, pat(i));
    end
    repeat (3) @(negedge clk);
    check("R12 hold", rdData, pat(15));
  endtask

  task automatic t_ident();
    logic [7:0] d;
    doReset();
    unlock();
    wr(12'h555, 8'h90);
    rd(12'h000, d); check("R3 R10 maker", d, 8'hC2);
    rd(12'h001, d); check("R10 device", d, 8'h93);
    rd(12'h002, d); check("R10 other", d, 8'h00);
    wr(12'h123, 8'hF0);
    rd(12'h000, d); check("R10 exit", d, pat(0));
  endtask

  task automatic t_mismatch();
    logic [7:0] d;
    doReset();
    unlock();
    wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h12);
    wr(12'h555, 8'h10);
    check("R5 no erase", {7'b0, rdyBusy}, 8'h01);
    wr(12'h555, 8'hAA);
    wr(12'h123, 8'h55);
    wr(12'h555, 8'h90);
    rd(12'h000, d); check("R5 no ident", d, pat(0));
  endtask

  task automatic t_chip();
    logic [7:0] d, d2;
    doReset();
    eraseHead();
    wr(12'h555, 8'h10);
    check("R6 busy start", {7'b0, rdyBusy}, 8'h00);
    repeat (NCYC - 1) @(negedge clk);
    check("R6 busy last cycle", {7'b0, rdyBusy}, 8'h00);
    @(negedge clk);
    check("R6 ready after count", {7'b0, rdyBusy}, 8'h01);
    for (int i = 0; i < 16; i += 3) begin
      rd(ADDR_W'(i), d);
      check("R9 chip FF", d, 8'hFF);
    end
    rd(12'h004, d); rd(12'h004, d2);
    check("R9 stable read", d2, d);
  endtask

  task automatic t_status_ignore();
    logic [7:0] d;
    doReset();
    eraseHead();
    wr(12'h555, 8'h10);
    rd(12'h007, d); q6Model = ~q6Model;
    check("R7 status 1", d, {1'b0, q6Model, 6'b0});
    rd(12'h007, d); q6Model = ~q6Model;
    check("R7 status 2", d, {1'b0, q6Model, 6'b0});
    unlock();
    wr(12'h555, 8'h90);
    check("R8 still busy", {7'b0, rdyBusy}, 8'h00);
    waitReady();
    check("R8 ready", {7'b0, rdyBusy}, 8'h01);
    rd(12'h000, d); check("R8 R9 array not ident", d, 8'hFF);
  endtask

  task automatic t_sector_late();
    logic [7:0] d;
    doReset();
    eraseHead();
    @(negedge clk);
    wrAddr = 12'h001; wrData = 8'h30; ceN = 1'b1; weN = 1'b0;
    @(negedge clk);
    wrAddr = 12'h009; ceN = 1'b0;
    @(negedge clk);
    weN = 1'b1;
    waitReady();
    for (int i = 0; i < 16; i++) begin
      rd(ADDR_W'(i), d);
      if (i >= 8 && i < 12) check("R2 R4 R9 sector FF", d, 8'hFF);
      else                  check("R2 R9 other kept", d, pat(i));
    end
  endtask

  task automatic t_abort();
    logic [7:0] d;
    doReset();
    eraseHead();
    wr(12'h555, 8'h10);
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R11 ready in reset", {7'b0, rdyBusy}, 8'h01);
    @(negedge clk);
    rstN = 1'b1;
    rd(12'h005, d); check("R11 array after abort", d, pat(5));
    repeat (NCYC + 2) @(negedge clk);
    check("R11 stays ready", {7'b0, rdyBusy}, 8'h01);
    rd(12'h005, d); check("R11 no late erase", d, pat(5));
  endtask

  initial begin
    t_reset();
    t_ident();
    t_mismatch();
    t_chip();
    t_status_ignore();
    t_sector_late();
    t_abort();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule